// File: doc/BRIEF.md
# SPI Mode-0 Register Bank Slave

This block is an SPI slave that gives an external master read and write access to a bank of 32 registers, each 16 bits wide. The bus runs in mode 0: the clock idles low, the master changes MOSI while the clock is low, and both sides sample on the rising edge. Every transaction is a fixed 32-bit frame sent MSB first. The upper 16 bits are a command word and the lower 16 bits are a data word.

The command word is laid out as follows. Bits [31:24] hold a synchronization pattern, 8'hA5 by default. Bit [23] is the read flag and bit [22] is the write flag. Bit [21] is reserved. Bits [20:16] hold the register address. A read shifts the addressed register out on MISO during bits 17 to 32 of the frame. A write stores the received data word once all 32 bits have arrived. When both flags are set, one frame returns the old value and then replaces it.

SCLK, chip select and MOSI are brought into the system clock domain through flop synchronizers, and the SCLK edges are detected in that domain. One SCLK half-period must therefore last at least four system clocks, so the system clock must run at least eight times faster than SCLK. The registers are held for on-chip consumers that are not part of this block.

Top module: `spi_regbank_slave`

## Requirements
- R1: After reset every register reads as 0 and MISO is low.
- R2: A frame with a matching sync pattern and the write flag (bit 22) set stores bits [15:0] into the register at address [20:16] once the 32nd rising SCLK edge has been received.
- R3: With a matching sync pattern and the read flag (bit 23) set, the addressed register appears on MISO MSB first, one bit per SCLK cycle, for rising edges 17 to 32. MISO is low during rising edges 1 to 16.
- R4: When read and write are both set, MISO carries the value the register held before the frame, and the new data is stored after the frame.
- R5: If bits [31:24] differ from the sync pattern, the frame writes nothing and MISO stays low for the whole frame.
- R6: Raising chip select before the 32nd rising edge aborts the frame with no write, and the next frame is decoded from its first bit.
- R7: MISO is low whenever no read is in progress, including while chip select is high and throughout write-only frames.
- R8: The reserved bit 21 has no effect on decoding.
- R9: Each of the 32 addresses selects its own register, and a write to one address leaves every other register unchanged.
- R10: SCLK edges after the 32nd within the same frame are ignored, and each frame performs at most one write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x the SCLK rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | SPI clock from the master, idles low |
| cs_ni | input | 1 | Chip select, active low |
| mosi_i | input | 1 | Serial data from the master |
| miso_o | output | 1 | Serial data to the master |

## Verification
The bound assertions check the following on every system clock:
- A write strobe fires only when a sync-matched command has been latched, occurs alone in its frame and leaves the counter at its terminal value.
- Shift-out is never active before the data half of the frame.
- Releasing chip select clears the counter and the read state.
- MISO is low after any cycle in which chip select is inactive.

Other behaviours can only be seen through the bench's frames:
- Data stored at one address and read back intact, with no aliasing to other addresses.
- The old-then-new ordering of a combined read and write.
- Aborted frames and frames with a bad sync pattern leaving the registers untouched.
- Excess SCLK edges leaving the stored word untouched.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;
  localparam int FRAME_W  = 32;
  localparam int HALF_W   = FRAME_W / 2;
  localparam int ADDR_W   = 5;
  localparam int SYNC_W   = 8;
  localparam int NUM_REGS = 1 << ADDR_W;
  localparam int CNT_W    = $clog2(FRAME_W + 1);
  // command field positions inside the 16-bit command word
  localparam int SYNC_LSB = HALF_W - SYNC_W;
  localparam int RD_BIT   = SYNC_LSB - 1;
  localparam int WR_BIT   = SYNC_LSB - 2;
  localparam int ADDR_LSB = 0;

  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [HALF_W-1:0] word_t;
endpackage

// File: rtl/spi_rb_sync.sv
module spi_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic cs_ni,
  input  logic mosi_i,
  output logic sclk_rise_o,
  output logic sclk_fall_o,
  output logic cs_act_o,
  output logic mosi_o
);
  localparam int NSIG = 3;
  localparam logic [NSIG-1:0] RST_VAL = 3'b010; // {mosi, cs_n, sclk}

  logic [NSIG-1:0] raw, synced;
  logic            sclk_d;

  assign raw = {mosi_i, cs_ni, sclk_i};

  for (genvar g = 0; g < NSIG; g++) begin : g_sig
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe <= {STAGES{RST_VAL[g]}};
      else         pipe <= {pipe[STAGES-2:0], raw[g]};
    end
    assign synced[g] = pipe[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_d <= 1'b0;
    else         sclk_d <= synced[0];
  end

  assign sclk_rise_o = synced[0] & ~sclk_d;
  assign sclk_fall_o = ~synced[0] & sclk_d;
  assign cs_act_o    = ~synced[1];
  assign mosi_o      = synced[2];
endmodule

// File: rtl/spi_rb_frame.sv
module spi_rb_frame
  import spi_rb_pkg::*;
#(
  parameter logic [SYNC_W-1:0] SYNC_VAL = 8'hA5
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  sclk_rise_i,
  input  logic  sclk_fall_i,
  input  logic  cs_act_i,
  input  logic  mosi_i,
  input  word_t rd_data_i,
  output addr_t addr_o,
  output logic  wr_en_o,
  output word_t wr_data_o,
  output logic  miso_o,
  output cnt_t  bit_cnt_o,
  output logic  tx_active_o,
  output logic  sync_ok_o
);
  localparam cnt_t CNT_HALF = cnt_t'(HALF_W);
  localparam cnt_t CNT_LAST = cnt_t'(FRAME_W - 1);
  localparam cnt_t CNT_FULL = cnt_t'(FRAME_W);

  cnt_t               bit_cnt;
  word_t              cmd_sr;
  logic [HALF_W-2:0]  data_sr;
  word_t              tx_sr;
  logic               tx_active;
  logic               cmd_done, cmd_match, rd_go;

  assign cmd_done  = (bit_cnt >= CNT_HALF);
  assign cmd_match = cmd_done && (cmd_sr[SYNC_LSB +: SYNC_W] == SYNC_VAL);
  assign rd_go     = cmd_match && cmd_sr[RD_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt   <= '0;
      cmd_sr    <= '0;
      data_sr   <= '0;
      tx_sr     <= '0;
      tx_active <= 1'b0;
    end else if (!cs_act_i) begin
      bit_cnt   <= '0;
      tx_sr     <= '0;
      tx_active <= 1'b0;
    end else begin
      if (sclk_rise_i && bit_cnt != CNT_FULL) begin
        bit_cnt <= bit_cnt + 1'b1;
        if (!cmd_done) cmd_sr  <= {cmd_sr[HALF_W-2:0], mosi_i};
        else           data_sr <= {data_sr[HALF_W-3:0], mosi_i};
      end
      // MISO advances after falling edges so it is stable at the next rise
      if (sclk_fall_i) begin
        if (bit_cnt == CNT_HALF && rd_go) begin
          tx_sr     <= rd_data_i;
          tx_active <= 1'b1;
        end else if (tx_active) begin
          if (bit_cnt == CNT_FULL) begin
            tx_active <= 1'b0;
            tx_sr     <= '0;
          end else begin
            tx_sr <= {tx_sr[HALF_W-2:0], 1'b0};
          end
        end
      end
    end
  end

  assign addr_o      = cmd_sr[ADDR_LSB +: ADDR_W];
  assign wr_en_o     = cs_act_i && sclk_rise_i && (bit_cnt == CNT_LAST)
                       && cmd_match && cmd_sr[WR_BIT];
  assign wr_data_o   = {data_sr, mosi_i};
  assign miso_o      = tx_active & tx_sr[HALF_W-1];
  assign bit_cnt_o   = bit_cnt;
  assign tx_active_o = tx_active;
  assign sync_ok_o   = cmd_match;
endmodule

// File: rtl/spi_rb_regfile.sv
module spi_rb_regfile
  import spi_rb_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_en_i,
  input  addr_t addr_i,
  input  word_t wr_data_i,
  output word_t rd_data_o
);
  word_t regs [NUM_REGS];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              regs[r] <= '0;
      else if (wr_en_i && addr_i == addr_t'(r)) regs[r] <= wr_data_i;
    end
  end

  assign rd_data_o = regs[addr_i];
endmodule

// File: rtl/spi_regbank_slave.sv
module spi_regbank_slave
  import spi_rb_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [SYNC_W-1:0] SYNC_VAL    = 8'hA5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic cs_ni,
  input  logic mosi_i,
  output logic miso_o
);
  logic  sclk_rise, sclk_fall, cs_act, mosi_s;
  logic  wr_en, tx_active, sync_ok;
  addr_t addr;
  word_t wr_data, rd_data;
  cnt_t  bit_cnt;

  spi_rb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sclk_i      (sclk_i),
    .cs_ni       (cs_ni),
    .mosi_i      (mosi_i),
    .sclk_rise_o (sclk_rise),
    .sclk_fall_o (sclk_fall),
    .cs_act_o    (cs_act),
    .mosi_o      (mosi_s)
  );

  spi_rb_frame #(.SYNC_VAL(SYNC_VAL)) u_frame (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sclk_rise_i (sclk_rise),
    .sclk_fall_i (sclk_fall),
    .cs_act_i    (cs_act),
    .mosi_i      (mosi_s),
    .rd_data_i   (rd_data),
    .addr_o      (addr),
    .wr_en_o     (wr_en),
    .wr_data_o   (wr_data),
    .miso_o      (miso_o),
    .bit_cnt_o   (bit_cnt),
    .tx_active_o (tx_active),
    .sync_ok_o   (sync_ok)
  );

  spi_rb_regfile u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .addr_i    (addr),
    .wr_data_i (wr_data),
    .rd_data_o (rd_data)
  );
endmodule

// File: rtl/spi_rb_chk.sv
module spi_rb_chk
  import spi_rb_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input logic cs_act,
  input logic miso_o,
  input logic wr_en,
  input cnt_t bit_cnt,
  input logic tx_active,
  input logic sync_ok
);
  // R2
  wr_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |=> bit_cnt == cnt_t'(FRAME_W));

  // R3
  rd_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_active |-> bit_cnt >= cnt_t'(HALF_W));

  // R5
  wr_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> sync_ok);

  // R6
  abort_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_act) |=> (bit_cnt == '0 && !tx_active));

  // R7
  idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_act |=> !miso_o);

  // R10
  single_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |=> !wr_en);
endmodule

bind spi_regbank_slave spi_rb_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_act    (cs_act),
  .miso_o    (miso_o),
  .wr_en     (wr_en),
  .bit_cnt   (bit_cnt),
  .tx_active (tx_active),
  .sync_ok   (sync_ok)
);

// File: tb/spi_regbank_slave_bench.sv
module spi_regbank_slave_bench;
  localparam int HALF = 4;          // system clocks per SCLK half-period
  localparam logic [7:0] SYNC = 8'hA5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso;
  int   checks = 0, errors = 0;
  bit   done = 1'b0;
  logic [15:0] model [32];

  always #4 clk = ~clk;

  spi_regbank_slave u_spi_regbank_slave (
    .clk_i (clk), .rst_ni (rst_n), .sclk_i (sclk),
    .cs_ni (cs_n), .mosi_i (mosi), .miso_o (miso)
  );

  function automatic logic [31:0] mk(input logic [7:0] s, input logic rd,
      input logic wr, input logic rsv, input logic [4:0] a, input logic [15:0] d);
    return {s, rd, wr, rsv, a, d};
  endfunction

  function automatic logic [15:0] exp_rd(input logic [31:0] w);
    if (w[31:24] == SYNC && w[23]) return model[w[20:16]];
    return 16'h0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // nbits bits of w, then extra clocks with MOSI high; got collects MISO at rises 1..32
  task automatic xfer(input logic [31:0] w, input int nbits, input int extra,
                      output logic [31:0] got);
    got = '0;
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits + extra; i++) begin
      mosi = (i < nbits) ? w[31-i] : 1'b1;
      repeat (HALF) @(negedge clk);
      if (i < 32) got[31-i] = miso;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    mosi = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic rd_reg(input logic [4:0] a, output logic [15:0] v);
    logic [31:0] g;
    xfer(mk(SYNC, 1'b1, 1'b0, 1'b0, a, 16'h0), 32, 0, g);
    v = g[15:0];
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [15:0] d);
    logic [31:0] g;
    xfer(mk(SYNC, 1'b0, 1'b1, 1'b0, a, d), 32, 0, g);
    check("R7 write-only frame MISO", g, 32'h0);
    model[a] = d;
  endtask

  initial begin
    logic [15:0] v;
    logic [31:0] g, w;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 32; i++) model[i] = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 MISO after reset", {31'h0, miso}, 32'h0);

    // R1: all registers clear
    for (int a = 0; a < 32; a++) begin
      rd_reg(5'(a), v);
      check("R1 reset value", {16'h0, v}, 32'h0);
    end

    // R2 / R9: distinct value per address, then read all back
    for (int a = 0; a < 32; a++) wr_reg(5'(a), 16'h1000 + 16'(a * 16'h0111));
    for (int a = 0; a < 32; a++) begin
      xfer(mk(SYNC, 1'b1, 1'b0, 1'b0, 5'(a), 16'h0), 32, 0, g);
      check("R3 MISO low in command half", {16'h0, g[31:16]}, 32'h0);
      check("R2 R9 readback", {16'h0, g[15:0]}, {16'h0, model[a]});
    end

    // R3: walking pattern exercises MSB-first order
    wr_reg(5'd7, 16'h8001);
    rd_reg(5'd7, v);
    check("R3 MSB-first shift", {16'h0, v}, 32'h8001);

    // R4: combined read and write
    xfer(mk(SYNC, 1'b1, 1'b1, 1'b0, 5'd3, 16'hBEEF), 32, 0, g);
    check("R4 old value out", {16'h0, g[15:0]}, {16'h0, model[3]});
    model[3] = 16'hBEEF;
    rd_reg(5'd3, v);
    check("R4 new value stored", {16'h0, v}, 32'hBEEF);

    // R5: bad sync, read+write flags set
    xfer(mk(8'h5A, 1'b1, 1'b1, 1'b0, 5'd3, 16'h1234), 32, 0, g);
    check("R5 MISO low on bad sync", g, 32'h0);
    rd_reg(5'd3, v);
    check("R5 no write on bad sync", {16'h0, v}, {16'h0, model[3]});

    // R6: abort in data half, then abort in command half
    xfer(mk(SYNC, 1'b0, 1'b1, 1'b0, 5'd9, 16'hDEAD), 31, 0, g);
    rd_reg(5'd9, v);
    check("R6 no write on late abort", {16'h0, v}, {16'h0, model[9]});
    xfer(mk(SYNC, 1'b0, 1'b1, 1'b0, 5'd9, 16'hDEAD), 10, 0, g);
    wr_reg(5'd9, 16'h0F0F);
    rd_reg(5'd9, v);
    check("R6 next frame decoded from bit 0", {16'h0, v}, 32'h0F0F);

    // R7: MISO idle with chip select high
    repeat (10) @(negedge clk);
    check("R7 MISO idle", {31'h0, miso}, 32'h0);

    // R8: reserved bit set
    xfer(mk(SYNC, 1'b0, 1'b1, 1'b1, 5'd12, 16'hA5A5), 32, 0, g);
    model[12] = 16'hA5A5;
    xfer(mk(SYNC, 1'b1, 1'b0, 1'b1, 5'd12, 16'h0), 32, 0, g);
    check("R8 reserved bit ignored", {16'h0, g[15:0]}, 32'hA5A5);

    // R10: extra SCLK edges after bit 32
    xfer(mk(SYNC, 1'b0, 1'b1, 1'b0, 5'd20, 16'h1230), 32, 3, g);
    model[20] = 16'h1230;
    rd_reg(5'd20, v);
    check("R10 extra edges ignored", {16'h0, v}, 32'h1230);
    rd_reg(5'd21, v);
    check("R9 R10 neighbour untouched", {16'h0, v}, {16'h0, model[21]});

    // random frames
    for (int n = 0; n < 150; n++) begin
      logic [7:0] s;
      s = ($urandom % 8 == 0) ? 8'($urandom) : SYNC;
      w = mk(s, 1'($urandom), 1'($urandom), 1'($urandom), 5'($urandom), 16'($urandom));
      xfer(w, 32, 0, g);
      check("R3 R5 random frame MISO", g, {16'h0, exp_rd(w)});
      if (s == SYNC && w[22]) model[w[20:16]] = w[15:0];
    end
    for (int a = 0; a < 32; a++) begin
      rd_reg(5'(a), v);
      check("R2 R9 final contents", {16'h0, v}, {16'h0, model[a]});
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule